// File: doc/BRIEF.md
# Trigger-Accept Windowed Readout Buffer

This block keeps a rolling record of the trigger stubs that arrive on every bunch crossing. Each crossing carries up to three stubs, and each stub is a 32-bit word. When a level-1 accept comes in, the block copies a five-crossing window out of that record into an output word FIFO. The window is centred on the crossing that caused the trigger, which lies a fixed latency before the accept. A header word comes first and carries the crossing number taken from a free-running 12-bit counter.

Accepts that arrive while a window is still being copied wait in a small queue. Some events cannot be stored in full. An event also cannot be stored when an earlier accept was lost. In both cases the header says so through flag bits. The block never sends old data again in place of new data.

Downstream logic drains the stream one 16-bit word at a time over a valid/ready handshake.

Top module: `l1a_window_buf`

## Requirements
- R1: `bx_count` advances by one on every clock cycle. It wraps from 3563 back to 0. It keeps counting while the output is stalled.
- R2: If `bc0` is high in a cycle, `bx_count` is 0 in the next cycle.
- R3: While `rst_n` is low, `out_valid` is 0 and `bx_count` is 0.
- R4: Every event starts with a header word laid out as follows:
  - bit 15 is the full flag.
  - bit 14 is the lost flag.
  - bits 13:12 are zero.
  - bits 11:0 hold the `bx_count` value seen in the cycle the accept was high.
- R5: For an accept in cycle t, the body covers the crossings recorded in cycles t-6 through t-2. These are sent in ascending order, so the trigger crossing t-4 sits at position 2. Each crossing starts with a mask word laid out as follows:
  - bits 10:8 hold the position, 0 to 4.
  - bits 2:0 hold the stub valid mask, where bit i stands for slot i.
  - all other bits are zero.
- R6: After each mask word, only the stubs that were present are sent, in ascending slot order. Each stub goes out as two words: bits 31:16 first, then bits 15:0.
- R7: Events leave in accept order. No word is repeated and none is dropped.
- R8: Up to four accepts can wait in the queue. An accept that arrives while four are waiting is discarded. The next header that is sent then has its lost flag set.
- R9: At the start of an event the block checks the output FIFO. If it has fewer than 36 free words, the event is sent as a header only, with the full flag set and no body.
- R10: If the output FIFO has no free word at all when an event starts, the event is discarded completely. The next header that is sent then has its lost flag set.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` holds its value. A word is consumed only on a cycle where both are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bc0 | input | 1 | Orbit marker that zeroes the crossing counter |
| l1a | input | 1 | Level-1 accept |
| stub_valid | input | 3 | Presence mask of the three stub slots in this crossing |
| stub_data | input | 96 | Stub slots; slot i sits at bits 32*i+31 down to 32*i |
| out_ready | input | 1 | Downstream can take a word |
| out_valid | output | 1 | A word is available |
| out_data | output | 16 | Output word |
| bx_count | output | 12 | Current crossing number |

## Verification
The main function is first driven with random stub masks and random data, with widely spaced accepts and a random `out_ready`. This shows that window alignment, mask encoding and slot order stay correct under back-pressure. A run of six back-to-back accepts fills the queue, which tells a correctly queued event apart from a discarded one and shows which header takes the lost flag. With the output stalled and every slot filled, a long series of accepts walks the output FIFO through three cases in turn: a full event fits, only a header-only event with the full flag fits, and no room is left at all. A bare run of the counter past 3563 and a set of `bc0` pulses separate the wrap from the orbit reset.

// File: rtl/l1w_pkg.sv
package l1w_pkg;

   typedef enum logic [1:0] {
      S_IDLE,
      S_MASK,
      S_FRAME
   } copy_state_e;

endpackage

// File: rtl/l1w_fifo.sv
module l1w_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 64
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [W-1:0]                 din,
   input  logic                         pop,
   output logic [W-1:0]                 dout,
   output logic                         empty,
   output logic [$clog2(DEPTH+1)-1:0]   count
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH+1);

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("l1w_fifo: DEPTH must be a power of two");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign do_push = push && (count != CW'(DEPTH));
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end
endmodule

// File: rtl/l1w_history.sv
module l1w_history #(
   parameter int W     = 99,
   parameter int DEPTH = 256
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [W-1:0]              wdata,
   input  logic [$clog2(DEPTH)-1:0]  raddr,
   output logic [W-1:0]              rdata,
   output logic [$clog2(DEPTH)-1:0]  wr_ptr
);
   localparam int AW = $clog2(DEPTH);

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("l1w_history: DEPTH must be a power of two");
   end

   logic [W-1:0] mem [DEPTH];

   assign rdata = mem[raddr];

   always_ff @(posedge clk) begin
      mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_ptr <= '0;
      else        wr_ptr <= wr_ptr + 1'b1;
   end
endmodule

// File: rtl/l1w_bxcnt.sv
module l1w_bxcnt #(
   parameter int BX_W      = 12,
   parameter int BX_PERIOD = 3564
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bc0,
   output logic [BX_W-1:0] bx
);
   if (BX_PERIOD > (1 << BX_W) || BX_PERIOD < 2) begin : g_bad_period
      $error("l1w_bxcnt: BX_PERIOD does not fit BX_W");
   end

   localparam logic [BX_W-1:0] LAST = BX_W'(BX_PERIOD - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           bx <= '0;
      else if (bc0)         bx <= '0;
      else if (bx == LAST)  bx <= '0;
      else                  bx <= bx + 1'b1;
   end
endmodule

// File: rtl/l1a_window_buf.sv
module l1a_window_buf
   import l1w_pkg::*;
#(
   parameter int SLOTS       = 3,
   parameter int FRAME_W     = 16,
   parameter int WIN         = 5,
   parameter int LAT         = 4,
   parameter int HIST_DEPTH  = 256,
   parameter int QDEPTH      = 4,
   parameter int OFIFO_DEPTH = 64,
   parameter int BX_W        = 12,
   parameter int BX_PERIOD   = 3564
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bc0,
   input  logic                         l1a,
   input  logic [SLOTS-1:0]             stub_valid,
   input  logic [SLOTS*2*FRAME_W-1:0]   stub_data,
   input  logic                         out_ready,
   output logic                         out_valid,
   output logic [FRAME_W-1:0]           out_data,
   output logic [BX_W-1:0]              bx_count
);
   localparam int STUB_W  = 2 * FRAME_W;
   localparam int ENT_W   = SLOTS * (1 + STUB_W);
   localparam int CENTER  = WIN / 2;
   localparam int HAW     = $clog2(HIST_DEPTH);
   localparam int CIDX_W  = (WIN > 1) ? $clog2(WIN) : 1;
   localparam int SLOT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1;
   localparam int EVT_MAX = 1 + WIN * (1 + 2 * SLOTS);
   localparam int QE_W    = HAW + BX_W;
   localparam int QCW     = $clog2(QDEPTH + 1);
   localparam int OCW     = $clog2(OFIFO_DEPTH + 1);

   if (LAT < WIN - 1 - CENTER) begin : g_bad_lat
      $error("l1a_window_buf: LAT too small for the window tail");
   end
   if (HIST_DEPTH < LAT + WIN + (QDEPTH + 1) * EVT_MAX + 2) begin : g_bad_hist
      $error("l1a_window_buf: HIST_DEPTH cannot cover queued copy delay");
   end
   if (OFIFO_DEPTH < EVT_MAX) begin : g_bad_ofifo
      $error("l1a_window_buf: OFIFO_DEPTH below one full event");
   end
   if (BX_W + 2 > FRAME_W || 8 + CIDX_W > FRAME_W || SLOTS > 8) begin : g_bad_word
      $error("l1a_window_buf: header or mask word does not fit FRAME_W");
   end

   // crossing counter
   l1w_bxcnt #(.BX_W(BX_W), .BX_PERIOD(BX_PERIOD)) u_bx (
      .clk(clk), .rst_n(rst_n), .bc0(bc0), .bx(bx_count));

   // rolling history of per-crossing stubs
   logic [HAW-1:0]   wr_ptr, raddr;
   logic [ENT_W-1:0] rd_ent;
   l1w_history #(.W(ENT_W), .DEPTH(HIST_DEPTH)) u_hist (
      .clk(clk), .rst_n(rst_n), .wdata({stub_data, stub_valid}),
      .raddr(raddr), .rdata(rd_ent), .wr_ptr(wr_ptr));

   // pending accepts: window start address and crossing number
   logic            q_empty, q_pop, q_push, q_drop, q_full;
   logic [QCW-1:0]  q_count;
   logic [QE_W-1:0] q_dout;
   logic [HAW-1:0]  q_addr, start_addr;
   logic [BX_W-1:0] q_bx;

   assign start_addr      = wr_ptr - HAW'(LAT + CENTER);
   assign q_full          = (q_count == QCW'(QDEPTH));
   assign q_push          = l1a && !q_full;
   assign q_drop          = l1a && q_full;
   assign {q_addr, q_bx}  = q_dout;

   l1w_fifo #(.W(QE_W), .DEPTH(QDEPTH)) u_acc_q (
      .clk(clk), .rst_n(rst_n), .push(q_push), .din({start_addr, bx_count}),
      .pop(q_pop), .dout(q_dout), .empty(q_empty), .count(q_count));

   // output word FIFO
   logic               o_push, o_empty;
   logic [FRAME_W-1:0] o_din;
   logic [OCW-1:0]     o_count, o_free;

   l1w_fifo #(.W(FRAME_W), .DEPTH(OFIFO_DEPTH)) u_out_q (
      .clk(clk), .rst_n(rst_n), .push(o_push), .din(o_din),
      .pop(out_valid && out_ready), .dout(out_data), .empty(o_empty),
      .count(o_count));

   assign out_valid = !o_empty;
   assign o_free    = OCW'(OFIFO_DEPTH) - o_count;

   // copy engine state
   copy_state_e             st, st_n;
   logic [HAW-1:0]          base, base_n;
   logic [CIDX_W-1:0]       cidx, cidx_n;
   logic [SLOT_W-1:0]       slot, slot_n;
   logic                    half, half_n, lost_q, hdr_push, drop_nr, last_c;
   logic [SLOTS-1:0]        emask, emask_n;
   logic [SLOTS*STUB_W-1:0] edata, edata_n;
   logic [SLOT_W:0]         found;
   logic [FRAME_W-1:0]      hdr_word, mask_word, frame_word;
   logic [STUB_W-1:0]       cur_stub;

   function automatic logic [SLOT_W:0] seek(input logic [SLOTS-1:0] m, input int from);
      seek = '0;
      for (int i = SLOTS - 1; i >= 0; i--) begin
         if (i >= from && m[i]) seek = {1'b1, SLOT_W'(i)};
      end
   endfunction

   assign raddr  = base + HAW'(cidx);
   assign last_c = (cidx == CIDX_W'(WIN - 1));

   always_comb begin
      hdr_word                = '0;
      hdr_word[FRAME_W-1]     = (o_free < OCW'(EVT_MAX));
      hdr_word[FRAME_W-2]     = lost_q;
      hdr_word[BX_W-1:0]      = q_bx;
      mask_word               = '0;
      mask_word[SLOTS-1:0]    = rd_ent[SLOTS-1:0];
      mask_word[8 +: CIDX_W]  = cidx;
      cur_stub                = edata[slot*STUB_W +: STUB_W];
      frame_word              = half ? cur_stub[FRAME_W-1:0] : cur_stub[STUB_W-1:FRAME_W];
   end

   always_comb begin
      st_n = st;  base_n = base;  cidx_n = cidx;  slot_n = slot;
      half_n = half;  emask_n = emask;  edata_n = edata;
      q_pop = 1'b0;  o_push = 1'b0;  o_din = '0;  hdr_push = 1'b0;
      drop_nr = 1'b0;  found = '0;
      unique case (st)
         S_IDLE: begin
            if (!q_empty) begin
               q_pop = 1'b1;
               if (o_free == '0) begin
                  drop_nr = 1'b1;
               end else begin
                  o_push   = 1'b1;
                  hdr_push = 1'b1;
                  o_din    = hdr_word;
                  if (!hdr_word[FRAME_W-1]) begin
                     st_n   = S_MASK;
                     base_n = q_addr;
                     cidx_n = '0;
                  end
               end
            end
         end
         S_MASK: begin
            o_push  = 1'b1;
            o_din   = mask_word;
            emask_n = rd_ent[SLOTS-1:0];
            edata_n = rd_ent[ENT_W-1:SLOTS];
            found   = seek(rd_ent[SLOTS-1:0], 0);
            if (found[SLOT_W]) begin
               st_n   = S_FRAME;
               slot_n = found[SLOT_W-1:0];
               half_n = 1'b0;
            end else if (last_c) begin
               st_n = S_IDLE;
            end else begin
               cidx_n = cidx + 1'b1;
            end
         end
         S_FRAME: begin
            o_push = 1'b1;
            o_din  = frame_word;
            if (!half) begin
               half_n = 1'b1;
            end else begin
               found = seek(emask, int'(slot) + 1);
               if (found[SLOT_W]) begin
                  slot_n = found[SLOT_W-1:0];
                  half_n = 1'b0;
               end else if (last_c) begin
                  st_n = S_IDLE;
               end else begin
                  cidx_n = cidx + 1'b1;
                  st_n   = S_MASK;
               end
            end
         end
         default: st_n = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE;  base <= '0;  cidx <= '0;  slot <= '0;  half <= 1'b0;
         emask <= '0;  edata <= '0;  lost_q <= 1'b0;
      end else begin
         st <= st_n;  base <= base_n;  cidx <= cidx_n;  slot <= slot_n;
         half <= half_n;  emask <= emask_n;  edata <= edata_n;
         lost_q <= (lost_q && !hdr_push) || q_drop || drop_nr;
      end
   end
endmodule

// File: rtl/l1w_checker.sv
module l1w_checker #(
   parameter int FRAME_W     = 16,
   parameter int BX_W        = 12,
   parameter int BX_PERIOD   = 3564,
   parameter int QDEPTH      = 4,
   parameter int OFIFO_DEPTH = 64,
   parameter int EVT_MAX     = 36
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          bc0,
   input logic [BX_W-1:0]               bx,
   input logic                          out_valid,
   input logic                          out_ready,
   input logic [FRAME_W-1:0]            out_data,
   input logic [$clog2(QDEPTH+1)-1:0]   q_count,
   input logic [$clog2(OFIFO_DEPTH+1)-1:0] o_count,
   input logic                          hdr_push,
   input logic                          o_push,
   input logic [FRAME_W-1:0]            hdr_word
);
   localparam int QCW = $clog2(QDEPTH + 1);
   localparam int OCW = $clog2(OFIFO_DEPTH + 1);

   a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!bc0 && bx != BX_W'(BX_PERIOD - 1)) |=> bx == $past(bx) + 1'b1);

   a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!bc0 && bx == BX_W'(BX_PERIOD - 1)) |=> bx == '0);

   a_r1_range: assert property (@(posedge clk) disable iff (!rst_n)
      bx < BX_W'(BX_PERIOD));

   a_r2_bc0_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bc0 |=> bx == '0);

   a_r8_queue_bound: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= QCW'(QDEPTH));

   a_r9_full_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_push && o_count > OCW'(OFIFO_DEPTH - EVT_MAX)) |-> hdr_word[FRAME_W-1]);

   a_r9_no_body: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_push && hdr_word[FRAME_W-1]) |=> (!o_push || hdr_push));

   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind l1a_window_buf l1w_checker #(
   .FRAME_W(FRAME_W), .BX_W(BX_W), .BX_PERIOD(BX_PERIOD),
   .QDEPTH(QDEPTH), .OFIFO_DEPTH(OFIFO_DEPTH), .EVT_MAX(EVT_MAX)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bc0(bc0), .bx(bx_count),
   .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
   .q_count(q_count), .o_count(o_count), .hdr_push(hdr_push),
   .o_push(o_push), .hdr_word(hdr_word)
);

// File: tb/l1a_window_buf_bench.sv
module l1a_window_buf_bench;
   localparam int CLK_P = 10;
   localparam int LAT   = 4;
   localparam int WIN   = 5;
   localparam int BXP   = 3564;

   logic        clk = 1'b0, rst_n = 1'b0, bc0 = 1'b0, l1a = 1'b0, out_ready = 1'b0;
   logic [2:0]  stub_valid = '0;
   logic [95:0] stub_data = '0;
   logic        out_valid;
   logic [15:0] out_data;
   logic [11:0] bx_count;

   l1a_window_buf u_l1a_window_buf (
      .clk(clk), .rst_n(rst_n), .bc0(bc0), .l1a(l1a), .stub_valid(stub_valid),
      .stub_data(stub_data), .out_ready(out_ready), .out_valid(out_valid),
      .out_data(out_data), .bx_count(bx_count));

   always #(CLK_P/2) clk = ~clk;

   int n_chk = 0, n_err = 0, n_rx = 0, n_exp = 0;
   int cyc = 0, bxm = 0;
   bit prev_bc0 = 0, reported = 0;
   int next_kind = 0;
   string next_tag = "R4";
   int stub_mode = 0;          // 0 idle, 1 random, 2 all slots present
   bit rand_ready = 0, fixed_ready = 1, rand_bc0 = 0;
   logic [2:0]  hv [16];
   logic [95:0] hd [16];
   logic [15:0] expq [$];
   string       exptag [$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      end
   endtask

   // kind: 0 normal, 1 lost flag, 2 header only with full flag, 3 discarded
   function automatic void build(input int t, input int bx, input int kind, input string htag);
      logic [2:0] m;
      int c;
      if (kind == 3) return;
      expq.push_back({kind == 2, kind == 1, 2'b00, bx[11:0]});
      exptag.push_back(htag);
      n_exp++;
      if (kind == 2) return;
      for (int p = 0; p < WIN; p++) begin
         c = t - LAT - 2 + p;
         m = hv[c % 16];
         expq.push_back({5'b0, p[2:0], 5'b0, m});
         exptag.push_back("R5");
         n_exp++;
         for (int s = 0; s < 3; s++) begin
            if (m[s]) begin
               expq.push_back(hd[c % 16][s*32+16 +: 16]);
               exptag.push_back("R6");
               expq.push_back(hd[c % 16][s*32 +: 16]);
               exptag.push_back("R6");
               n_exp += 2;
            end
         end
      end
   endfunction

   // input recorder and counter model, sampled mid-cycle
   always begin
      @(negedge clk); #1;
      if (!rst_n) begin
         cyc = 0; bxm = 0; prev_bc0 = 0;
      end else begin
         chk(bx_count == bxm[11:0], prev_bc0 ? "R2 counter after bc0" : "R1 counter",
             int'(bx_count), bxm);
         hv[cyc % 16] = stub_valid;
         hd[cyc % 16] = stub_data;
         if (l1a) build(cyc, bxm, next_kind, next_tag);
         prev_bc0 = bc0;
         bxm = bc0 ? 0 : ((bxm == BXP - 1) ? 0 : bxm + 1);
         cyc++;
      end
   end

   // output collector
   always begin
      @(negedge clk); #1;
      if (rst_n && out_valid && out_ready) begin
         n_rx++;
         if (expq.size() == 0) begin
            chk(0, "R7 unexpected word", int'(out_data), 0);
         end else begin
            logic [15:0] e;
            string tg;
            e = expq.pop_front();
            tg = exptag.pop_front();
            chk(out_data == e, tg, int'(out_data), int'(e));
         end
      end
   end

   // background stimulus
   always begin
      @(negedge clk);
      out_ready = rand_ready ? ($urandom_range(0, 3) != 0) : fixed_ready;
      bc0 = rand_bc0 && ($urandom_range(0, 299) == 0);
      case (stub_mode)
         1: begin
            stub_valid = 3'($urandom_range(0, 7));
            stub_data  = {$urandom(), $urandom(), $urandom()};
         end
         2: begin
            stub_valid = 3'b111;
            stub_data  = {$urandom(), $urandom(), $urandom()};
         end
         default: begin
            stub_valid = '0;
            stub_data  = '0;
         end
      endcase
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic fire(input int kind, input string tag);
      @(negedge clk);
      next_kind = kind;
      next_tag  = tag;
      l1a = 1'b1;
      @(negedge clk);
      l1a = 1'b0;
      next_kind = 0;
      next_tag  = "R4";
   endtask

   task automatic drain();
      int guard = 0;
      while (expq.size() != 0 && guard < 5000) begin
         tick(1);
         guard++;
      end
      tick(4);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      report();
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240917));
      fixed_ready = 1;
      tick(5);
      #1;
      chk(out_valid == 1'b0, "R3 valid in reset", int'(out_valid), 0);
      chk(bx_count == 12'd0, "R3 counter in reset", int'(bx_count), 0);
      @(negedge clk);
      rst_n = 1'b1;
      tick(3);
      #1;
      chk(out_valid == 1'b0, "R3 idle after reset", int'(out_valid), 0);

      // counter wrap (R1) and orbit marker (R2)
      stub_mode = 1;
      tick(3700);
      for (int k = 0; k < 4; k++) begin
         tick($urandom_range(20, 200));
         bc0 = 1'b1;   // held only for this cycle; background overrides next
      end
      rand_bc0 = 1;

      // random windows under back-pressure: R4, R5, R6, R7, R11
      rand_ready = 1;
      for (int ev = 0; ev < 60; ev++) begin
         fire(0, "R4");
         tick($urandom_range(60, 120));
      end
      rand_ready = 0;
      fixed_ready = 1;
      rand_bc0 = 0;
      drain();
      chk(n_rx == n_exp, "R11 words delivered", n_rx, n_exp);

      // six back-to-back accepts: fifth pending fits, sixth dropped (R8)
      @(negedge clk); next_kind = 0; next_tag = "R4"; l1a = 1'b1;
      @(negedge clk); next_kind = 1; next_tag = "R8";
      @(negedge clk); next_kind = 0; next_tag = "R4";
      @(negedge clk);
      @(negedge clk);
      @(negedge clk); next_kind = 3;
      @(negedge clk); l1a = 1'b0; next_kind = 0;
      drain();

      // output FIFO pressure: full event, header-only events, discard (R9, R10)
      stub_mode = 2;
      tick(10);
      fixed_ready = 0;
      fire(0, "R4");
      tick(50);
      for (int k = 0; k < 28; k++) begin
         fire(2, "R9");
         tick(1);
      end
      fire(3, "R10");
      tick(5);
      #1;
      chk(out_valid == 1'b1, "R11 stalled word pending", int'(out_valid), 1);
      fixed_ready = 1;
      drain();
      fire(1, "R10");
      tick(5);
      drain();

      tick(50);
      chk(expq.size() == 0, "R7 all events emitted", expq.size(), 0);
      #1;
      chk(out_valid == 1'b0, "R7 nothing extra", int'(out_valid), 0);
      report();
      $finish;
   end
endmodule